// File: doc/BRIEF.md
# Reversible-gate Wallace tree multiplier

This block multiplies two 4-bit unsigned operands into an 8-bit product. Every logic function inside it is built from two reversible primitives. One is a 2-input controlled-NOT gate, which passes its control through and XORs it into its target. The other is a 3-input controlled-controlled-NOT gate, which passes both controls through and XORs their AND into its target.

Each partial product is one controlled-controlled-NOT gate with its target tied low. Any operand bit that must reach several gates is first copied through a chain of controlled-NOT gates, so no gate output drives more than one input. The 4x4 partial product array is reduced with Wallace carry-save grouping: three rows at a time, with full adders on three-bit columns, half adders on two-bit columns, and single bits passed through. A ripple adder then sums the last two rows. The reversible outputs that the arithmetic does not use are kept and brought out on a garbage bus.

A parameter selects whether the product leaves straight from the logic or through a register with a synchronous reset. The block has no flow control. Operands are sampled whenever they are present and carry no handshake, so there is no back-pressure to manage.

Top module: `rev_wallace_mul4`

## Requirements
- R1: With the output register disabled, `prod_o` equals `mcand_i * mplier_i` (unsigned) for every one of the 256 operand pairs.
- R2: With the output register enabled, each rising edge of `clk_i` with `rst_i` low loads `prod_o` with the product of the operands present at that edge. The product therefore appears one cycle after the operands.
- R3: With the output register enabled, a rising edge with `rst_i` high clears `prod_o` to zero whatever the operands are. The first edge after `rst_i` falls loads the product again.
- R4: The reset is synchronous: raising `rst_i` between edges leaves `prod_o` unchanged until the next rising edge.
- R5: For partial-product term (row i of the multiplier bit, column j of the multiplicand bit), `junk_o[2*(4*i+j)]` carries `mcand_i[j]` and `junk_o[2*(4*i+j)+1]` carries `mplier_i[i]`, combinationally in both variants. Bits 32 to 51 carry the unused adder outputs.
- R6: A zero operand gives a zero product, and the largest operands (15 and 15) give 225, with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| mcand_i | input | 4 | Multiplicand |
| mplier_i | input | 4 | Multiplier |
| prod_o | output | 8 | Product, registered or combinational depending on `REG_OUT` |
| junk_o | output | 52 | Unused reversible-gate outputs (garbage) |

## Verification
The combinational assertions in the adders and at the top assume known operand values. They skip any evaluation in which an operand is unknown, and the stimulus drives defined operands from time zero. The latency property assumes reset is held across at least one rising edge before the first real operands, which the stimulus does. All operands change only on falling edges, so every capture edge sees stable inputs.

// File: rtl/rev_pkg.sv
package rev_pkg;
  // operand and product widths
  localparam int OPW = 4;
  localparam int PW  = 2 * OPW;
  // adder population of the 4x4 Wallace tree (stage 1, stage 2, final ripple)
  localparam int NUM_HA = 4;
  localparam int NUM_FA = 8;
  // garbage bus layout
  localparam int PP_GARB  = 2 * OPW * OPW;
  localparam int HA_BASE  = PP_GARB;
  localparam int FA_BASE  = HA_BASE + NUM_HA;
  localparam int GARB_W   = PP_GARB + NUM_HA + 2 * NUM_FA;
endpackage

// File: rtl/rev_gates.sv
// 2x2 controlled-NOT: control passes, target flipped by control
module rev_cnot (
  input  logic ctl_i,
  input  logic tgt_i,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = ctl_i ^ tgt_i;
endmodule

// 3x3 controlled-controlled-NOT: both controls pass, target flipped by their AND
module rev_ccnot (
  input  logic c1_i,
  input  logic c2_i,
  input  logic tgt_i,
  output logic c1_o,
  output logic c2_o,
  output logic tgt_o
);
  assign c1_o  = c1_i;
  assign c2_o  = c2_i;
  assign tgt_o = (c1_i & c2_i) ^ tgt_i;
endmodule

// File: rtl/rev_fanout.sv
// Copies one bit onto COPIES wires through a chain of controlled-NOT gates,
// each with its target tied low; every gate output feeds exactly one load.
module rev_fanout #(
  parameter int COPIES = 4
) (
  input  logic              x_i,
  output logic [COPIES-1:0] y_o
);
  logic [COPIES-1:0] pass;
  assign pass[0] = x_i;

  for (genvar k = 0; k < COPIES - 1; k++) begin : g_copy
    rev_cnot u_cp (
      .ctl_i (pass[k]),
      .tgt_i (1'b0),
      .ctl_o (pass[k+1]),
      .tgt_o (y_o[k])
    );
  end
  assign y_o[COPIES-1] = pass[COPIES-1];
endmodule

// File: rtl/rev_adders.sv
// Half adder: one 3x3 gate makes the carry, one 2x2 gate makes the sum.
module rev_half_adder (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cry_o,
  output logic junk_o
);
  logic a1, b1;

  rev_ccnot u_and (
    .c1_i (a_i), .c2_i (b_i), .tgt_i (1'b0),
    .c1_o (a1),  .c2_o (b1),  .tgt_o (cry_o)
  );
  rev_cnot u_xor (
    .ctl_i (a1), .tgt_i (b1),
    .ctl_o (junk_o), .tgt_o (sum_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      ha_excl_chk: assert (!(sum_o && cry_o))
        else $error("half adder drove sum and carry together");
    end
  end
endmodule

// Full adder: AND of a,b; XOR of a,b; majority folded into the first AND's
// target; final XOR with the carry-in gives the sum.
module rev_full_adder (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       c_i,
  output logic       sum_o,
  output logic       cry_o,
  output logic [1:0] junk_o
);
  logic a1, b1, ab, b2, axb, c2, axb2;

  rev_ccnot u_and1 (
    .c1_i (a_i), .c2_i (b_i), .tgt_i (1'b0),
    .c1_o (a1),  .c2_o (b1),  .tgt_o (ab)
  );
  rev_cnot u_xor1 (
    .ctl_i (a1), .tgt_i (b1),
    .ctl_o (junk_o[0]), .tgt_o (b2)
  );
  assign axb = b2;
  rev_ccnot u_and2 (
    .c1_i (axb),  .c2_i (c_i), .tgt_i (ab),
    .c1_o (axb2), .c2_o (c2),  .tgt_o (cry_o)
  );
  rev_cnot u_xor2 (
    .ctl_i (axb2), .tgt_i (c2),
    .ctl_o (junk_o[1]), .tgt_o (sum_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1
      fa_count_chk: assert ({cry_o, sum_o} == (2'(a_i) + 2'(b_i) + 2'(c_i)))
        else $error("full adder count mismatch");
    end
  end
endmodule

// File: rtl/rev_wallace_mul4.sv
module rev_wallace_mul4
  import rev_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [OPW-1:0]    mcand_i,
  input  logic [OPW-1:0]    mplier_i,
  output logic [PW-1:0]     prod_o,
  output logic [GARB_W-1:0] junk_o
);
  // ---------------- operand duplication ----------------
  logic [OPW-1:0] a_cp [OPW];   // a_cp[j][i] : copy of mcand bit j for row i
  logic [OPW-1:0] b_cp [OPW];   // b_cp[i][j] : copy of mplier bit i for column j

  for (genvar n = 0; n < OPW; n++) begin : g_dup
    rev_fanout #(.COPIES(OPW)) u_fa_a (.x_i(mcand_i[n]),  .y_o(a_cp[n]));
    rev_fanout #(.COPIES(OPW)) u_fa_b (.x_i(mplier_i[n]), .y_o(b_cp[n]));
  end

  // ---------------- partial products ----------------
  logic [OPW-1:0] pp [OPW];     // pp[i][j] = mcand[j] & mplier[i], weight i+j

  for (genvar i = 0; i < OPW; i++) begin : g_row
    for (genvar j = 0; j < OPW; j++) begin : g_col
      rev_ccnot u_pp (
        .c1_i  (a_cp[j][i]),
        .c2_i  (b_cp[i][j]),
        .tgt_i (1'b0),
        .c1_o  (junk_o[2*(OPW*i+j)]),
        .c2_o  (junk_o[2*(OPW*i+j)+1]),
        .tgt_o (pp[i][j])
      );
    end
  end

  // ---------------- Wallace stage 1: rows 0..2 ----------------
  logic s1_c1, s1_c2, s1_c3, s1_c4;     // sums by column
  logic k1_c2, k1_c3, k1_c4, k1_c5;     // carries by column of weight

  rev_half_adder u_s1_h1 (
    .a_i (pp[0][1]), .b_i (pp[1][0]),
    .sum_o (s1_c1), .cry_o (k1_c2), .junk_o (junk_o[HA_BASE+0])
  );
  rev_full_adder u_s1_f2 (
    .a_i (pp[0][2]), .b_i (pp[1][1]), .c_i (pp[2][0]),
    .sum_o (s1_c2), .cry_o (k1_c3), .junk_o (junk_o[FA_BASE+0 +: 2])
  );
  rev_full_adder u_s1_f3 (
    .a_i (pp[0][3]), .b_i (pp[1][2]), .c_i (pp[2][1]),
    .sum_o (s1_c3), .cry_o (k1_c4), .junk_o (junk_o[FA_BASE+2 +: 2])
  );
  rev_half_adder u_s1_h4 (
    .a_i (pp[1][3]), .b_i (pp[2][2]),
    .sum_o (s1_c4), .cry_o (k1_c5), .junk_o (junk_o[HA_BASE+1])
  );

  // ---------------- Wallace stage 2: sums, carries, row 3 ----------------
  logic t_c2, t_c3, t_c4, t_c5;
  logic d_c3, d_c4, d_c5, d_c6;

  rev_half_adder u_s2_h2 (
    .a_i (s1_c2), .b_i (k1_c2),
    .sum_o (t_c2), .cry_o (d_c3), .junk_o (junk_o[HA_BASE+2])
  );
  rev_full_adder u_s2_f3 (
    .a_i (s1_c3), .b_i (k1_c3), .c_i (pp[3][0]),
    .sum_o (t_c3), .cry_o (d_c4), .junk_o (junk_o[FA_BASE+4 +: 2])
  );
  rev_full_adder u_s2_f4 (
    .a_i (s1_c4), .b_i (k1_c4), .c_i (pp[3][1]),
    .sum_o (t_c4), .cry_o (d_c5), .junk_o (junk_o[FA_BASE+6 +: 2])
  );
  rev_full_adder u_s2_f5 (
    .a_i (pp[2][3]), .b_i (k1_c5), .c_i (pp[3][2]),
    .sum_o (t_c5), .cry_o (d_c6), .junk_o (junk_o[FA_BASE+8 +: 2])
  );

  // ---------------- carry-propagating adder on the last two rows ----------------
  logic [PW-1:0] prod_c;
  logic r_c4, r_c5, r_c6;

  assign prod_c[0] = pp[0][0];
  assign prod_c[1] = s1_c1;
  assign prod_c[2] = t_c2;

  rev_half_adder u_cp_h3 (
    .a_i (t_c3), .b_i (d_c3),
    .sum_o (prod_c[3]), .cry_o (r_c4), .junk_o (junk_o[HA_BASE+3])
  );
  rev_full_adder u_cp_f4 (
    .a_i (t_c4), .b_i (d_c4), .c_i (r_c4),
    .sum_o (prod_c[4]), .cry_o (r_c5), .junk_o (junk_o[FA_BASE+10 +: 2])
  );
  rev_full_adder u_cp_f5 (
    .a_i (t_c5), .b_i (d_c5), .c_i (r_c5),
    .sum_o (prod_c[5]), .cry_o (r_c6), .junk_o (junk_o[FA_BASE+12 +: 2])
  );
  rev_full_adder u_cp_f6 (
    .a_i (pp[3][3]), .b_i (d_c6), .c_i (r_c6),
    .sum_o (prod_c[6]), .cry_o (prod_c[7]), .junk_o (junk_o[FA_BASE+14 +: 2])
  );

  always_comb begin
    if (!$isunknown({mcand_i, mplier_i})) begin
      // R1
      prod_val_chk: assert (prod_c == PW'(mcand_i) * PW'(mplier_i))
        else $error("tree product mismatch");
      for (int i = 0; i < OPW; i++) begin
        for (int j = 0; j < OPW; j++) begin
          // R5
          pp_copy_chk: assert (junk_o[2*(OPW*i+j)] == mcand_i[j] &&
                               junk_o[2*(OPW*i+j)+1] == mplier_i[i])
            else $error("partial-product garbage does not carry operand bits");
        end
      end
    end
  end

  // ---------------- output stage ----------------
  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) prod_q <= '0;
      else       prod_q <= prod_c;
    end
    assign prod_o = prod_q;

    // R2
    reg_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> prod_o == $past(PW'(mcand_i) * PW'(mplier_i)))
      else $error("registered product latency mismatch");
  end else begin : g_comb
    assign prod_o = prod_c;
  end
endmodule

// File: tb/sim_rev_wallace_mul4.sv
module sim_rev_wallace_mul4;
  import rev_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [OPW-1:0]    a, b;
  logic [PW-1:0]     y_reg, y_cmb;
  logic [GARB_W-1:0] g_reg, g_cmb;

  int n_chk = 0;
  int n_bad = 0;
  int ref_y = 0;
  bit started = 1'b0;
  bit ref_rst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_wallace_mul4 #(.REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_i(rst), .mcand_i(a), .mplier_i(b),
    .prod_o(y_reg), .junk_o(g_reg)
  );
  rev_wallace_mul4 #(.REG_OUT(1'b0)) u1 (
    .clk_i(clk), .rst_i(rst), .mcand_i(a), .mplier_i(b),
    .prod_o(y_cmb), .junk_o(g_cmb)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference of the registered variant
  always @(posedge clk) begin
    ref_rst <= rst;
    ref_y   <= rst ? 0 : int'(a) * int'(b);
    started <= 1'b1;
  end

  // compare the registered output on every clock
  always @(negedge clk) begin
    if (started) check(ref_rst ? "R3 registered reset" : "R2 registered product",
                       y_reg, ref_y);
  end

  // expected partial-product garbage from R5
  function automatic logic [PP_GARB-1:0] exp_garb(input logic [OPW-1:0] x,
                                                  input logic [OPW-1:0] z);
    logic [PP_GARB-1:0] g;
    for (int i = 0; i < OPW; i++)
      for (int j = 0; j < OPW; j++) begin
        g[2*(OPW*i+j)]   = x[j];
        g[2*(OPW*i+j)+1] = z[i];
      end
    return g;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    a = '0;
    b = '0;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 reset state", y_reg, 0);
    rst = 1'b0;

    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      a = OPW'(p >> 4);
      b = OPW'(p);
      #1;
      check("R1 combinational product", y_cmb, int'(a) * int'(b));
      check("R5 operand copies", g_cmb[PP_GARB-1:0], exp_garb(a, b));
      if (a == 0 || b == 0) check("R6 zero operand", y_cmb, 0);
      if (a == 15 && b == 15) check("R6 largest product", y_cmb, 225);
    end

    // R4 / R3: synchronous reset with live operands
    @(negedge clk);
    a = 4'd15;
    b = 4'd15;
    @(negedge clk);
    check("R6 registered largest", y_reg, 225);
    rst = 1'b1;
    #1;
    check("R4 reset waits for edge", y_reg, 225);
    @(negedge clk);
    check("R3 reset overrides operands", y_reg, 0);
    a = 4'd9;
    b = 4'd13;
    @(negedge clk);
    check("R3 reset held", y_reg, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 capture after release", y_reg, 117);
    check("R5 registered variant copies", g_reg[PP_GARB-1:0], exp_garb(a, b));
    @(negedge clk);
    finish_run();
  end
endmodule